// File: doc/BRIEF.md
# Return-from-Trap Checker

This unit decides whether a return-from-trap instruction may complete. When the instruction executes, the pipeline presents the current status fields, the per-window invalid mask and the already computed return address together with an execute strobe. These are the supervisor bit, the previous-supervisor bit, the trap-enable bit and the current window pointer. The unit runs four checks in a fixed priority order, and only the first failing check is reported.

When every check passes, the unit hands back the restored status. The privilege level is copied from the previous-supervisor bit, traps are enabled again and the window pointer moves up by one. It also raises a branch request carrying the return address. When a check fails, it raises a trap request with that check's trap type and returns the incoming status unchanged.

All results are registered. They appear on the clock edge that samples the strobe, and the status outputs hold their value until the next strobe.

Top module: `rett_unit`

## Requirements
- R1: After reset, `branchReq` and `trapReq` are 0, `trapType` is 8'h00, and `outSup`, `outPrevSup`, `outTrapEn` and `outWinPtr` are all 0.
- R2: A strobe with `supMode` = 0 yields a trap request of type 8'h03, whatever the other inputs are.
- R3: A strobe with `supMode` = 1 and `trapEn` = 1 yields a trap request of type 8'h02, whatever the mask and address are.
- R4: A strobe with `supMode` = 1 and `trapEn` = 0 yields a trap request of type 8'h06 when `winInvalid` bit number ((`winPtr` + 1) mod 8) is 1. Here bit n of the mask belongs to window n.
- R5: A strobe that passes R2 to R4 but has a nonzero value in `retAddr[1:0]` yields a trap request of type 8'h07.
- R6: A strobe that passes all checks sets `outSup` to `prevSup` and `outTrapEn` to 1. It passes `prevSup` through to `outPrevSup` and sets `outWinPtr` to (`winPtr` + 1) mod 8, so 7 wraps to 0.
- R7: A strobe that passes all checks raises `branchReq` with `branchTarget` equal to `retAddr`.
- R8: A strobe that fails a check leaves `outSup`, `outPrevSup`, `outTrapEn` and `outWinPtr` equal to the incoming status fields, and raises no branch.
- R9: Each strobe makes exactly one of `branchReq` and `trapReq` high for one cycle, on the edge that samples it. Without a strobe, both are low.
- R10: Without a strobe, the status outputs keep their previous values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execStb | input | 1 | Return-from-trap executes this cycle |
| supMode | input | 1 | Current supervisor bit |
| prevSup | input | 1 | Previous-supervisor bit |
| trapEn | input | 1 | Current trap-enable bit |
| winPtr | input | 3 | Current window pointer |
| winInvalid | input | 8 | Invalid-window mask, bit n for window n |
| retAddr | input | 32 | Computed return address |
| branchReq | output | 1 | Branch to return address requested |
| branchTarget | output | 32 | Return address of the last successful return |
| trapReq | output | 1 | Trap requested |
| trapType | output | 8 | Trap type of the first failing check |
| outSup | output | 1 | Resulting supervisor bit |
| outPrevSup | output | 1 | Resulting previous-supervisor bit |
| outTrapEn | output | 1 | Resulting trap-enable bit |
| outWinPtr | output | 3 | Resulting window pointer |

## Verification
Every result of this unit is due one clock edge after the strobe. This covers the branch or trap pulse, the trap type, the target and the restored status. The bench drives inputs on the falling edge. The monitor records whether the strobe was present at the next rising edge and compares 2 ns after that edge. A recorded strobe pops exactly one expected item from the scoreboard. A cycle without a strobe is instead checked for absent pulses and held status, so a stale or early result is caught on the cycle it appears.

// File: rtl/rett_pkg.sv
`timescale 1ns/1ps
package rett_pkg;

  localparam logic [7:0] TT_ILLEGAL   = 8'h02;
  localparam logic [7:0] TT_PRIV      = 8'h03;
  localparam logic [7:0] TT_WIN_UNDER = 8'h06;
  localparam logic [7:0] TT_UNALIGNED = 8'h07;

  // Command from the check logic to the state datapath
  typedef struct packed {
    logic       takeBranch;
    logic       raiseTrap;
    logic [7:0] trapCode;
  } rettCmd_t;

endpackage

// File: rtl/rett_check_ctrl.sv
`timescale 1ns/1ps
module rett_check_ctrl
  import rett_pkg::*;
#(
  parameter int WIN_COUNT  = 8,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  localparam int PTR_W     = $clog2(WIN_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 execStb,
  input  logic                 supMode,
  input  logic                 trapEn,
  input  logic [PTR_W-1:0]     winPtr,
  input  logic [WIN_COUNT-1:0] winInvalid,
  input  logic [ADDR_W-1:0]    retAddr,
  output rettCmd_t             cmd
);

  logic [PTR_W-1:0]     destWin;
  logic [WIN_COUNT-1:0] destHit;
  logic                 destInvalid;
  logic                 misaligned;

  // Destination window, modulo the window count
  assign destWin = (winPtr == PTR_W'(WIN_COUNT - 1)) ? '0 : winPtr + 1'b1;

  // One-hot select of the destination window's invalid bit
  for (genvar g = 0; g < WIN_COUNT; g++) begin : gDest
    assign destHit[g] = (destWin == PTR_W'(g)) & winInvalid[g];
  end
  assign destInvalid = |destHit;

  assign misaligned = |retAddr[ALIGN_BITS-1:0];

  // Fixed priority: privilege, trap enable, window, alignment
  always_comb begin
    cmd = '0;
    if (execStb) begin
      if (!supMode) begin
        cmd.raiseTrap = 1'b1;
        cmd.trapCode  = TT_PRIV;
      end else if (trapEn) begin
        cmd.raiseTrap = 1'b1;
        cmd.trapCode  = TT_ILLEGAL;
      end else if (destInvalid) begin
        cmd.raiseTrap = 1'b1;
        cmd.trapCode  = TT_WIN_UNDER;
      end else if (misaligned) begin
        cmd.raiseTrap = 1'b1;
        cmd.trapCode  = TT_UNALIGNED;
      end else begin
        cmd.takeBranch = 1'b1;
      end
    end
  end

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    execStb |-> (cmd.takeBranch != cmd.raiseTrap)); // R9
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !execStb |-> (!cmd.takeBranch && !cmd.raiseTrap)); // R9
  AST_UNALIGNED_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.raiseTrap && cmd.trapCode == TT_UNALIGNED) |-> (supMode && !trapEn && !destInvalid)); // R5

endmodule

// File: rtl/rett_state_dp.sv
`timescale 1ns/1ps
module rett_state_dp
  import rett_pkg::*;
#(
  parameter int WIN_COUNT = 8,
  parameter int ADDR_W    = 32,
  localparam int PTR_W    = $clog2(WIN_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execStb,
  input  rettCmd_t          cmd,
  input  logic              supMode,
  input  logic              prevSup,
  input  logic              trapEn,
  input  logic [PTR_W-1:0]  winPtr,
  input  logic [ADDR_W-1:0] retAddr,
  output logic              branchReq,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              trapReq,
  output logic [7:0]        trapType,
  output logic              outSup,
  output logic              outPrevSup,
  output logic              outTrapEn,
  output logic [PTR_W-1:0]  outWinPtr
);

  function automatic logic [PTR_W-1:0] stepWin(input logic [PTR_W-1:0] w);
    return (w == PTR_W'(WIN_COUNT - 1)) ? '0 : w + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      branchReq    <= 1'b0;
      trapReq      <= 1'b0;
      trapType     <= '0;
      branchTarget <= '0;
      outSup       <= 1'b0;
      outPrevSup   <= 1'b0;
      outTrapEn    <= 1'b0;
      outWinPtr    <= '0;
    end else begin
      branchReq <= cmd.takeBranch;
      trapReq   <= cmd.raiseTrap;
      if (cmd.raiseTrap) trapType <= cmd.trapCode;
      if (execStb) begin
        outPrevSup <= prevSup;
        if (cmd.takeBranch) begin
          branchTarget <= retAddr;
          outSup       <= prevSup;
          outTrapEn    <= 1'b1;
          outWinPtr    <= stepWin(winPtr);
        end else begin
          outSup    <= supMode;
          outTrapEn <= trapEn;
          outWinPtr <= winPtr;
        end
      end
    end
  end

  AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && !supMode) |=> (trapReq && trapType == TT_PRIV)); // R2
  AST_ILLEGAL_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && supMode && trapEn) |=> (trapReq && trapType == TT_ILLEGAL)); // R3
  AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && cmd.takeBranch) |=> (outWinPtr == stepWin($past(winPtr)) && outTrapEn && outSup == $past(prevSup))); // R6
  AST_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && cmd.takeBranch) |=> (branchReq && branchTarget == $past(retAddr))); // R7
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && cmd.raiseTrap) |=> (!branchReq && outWinPtr == $past(winPtr) && outSup == $past(supMode) && outTrapEn == $past(trapEn))); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> (branchReq != trapReq)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !execStb |=> (!branchReq && !trapReq && $stable(outWinPtr) && $stable(outSup) && $stable(outTrapEn))); // R10

endmodule

// File: rtl/rett_unit.sv
`timescale 1ns/1ps
module rett_unit
  import rett_pkg::*;
#(
  parameter int WIN_COUNT  = 8,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  localparam int PTR_W     = $clog2(WIN_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 execStb,
  input  logic                 supMode,
  input  logic                 prevSup,
  input  logic                 trapEn,
  input  logic [PTR_W-1:0]     winPtr,
  input  logic [WIN_COUNT-1:0] winInvalid,
  input  logic [ADDR_W-1:0]    retAddr,
  output logic                 branchReq,
  output logic [ADDR_W-1:0]    branchTarget,
  output logic                 trapReq,
  output logic [7:0]           trapType,
  output logic                 outSup,
  output logic                 outPrevSup,
  output logic                 outTrapEn,
  output logic [PTR_W-1:0]     outWinPtr
);

  rettCmd_t cmd;

  rett_check_ctrl #(
    .WIN_COUNT(WIN_COUNT), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .execStb(execStb), .supMode(supMode),
    .trapEn(trapEn), .winPtr(winPtr), .winInvalid(winInvalid),
    .retAddr(retAddr), .cmd(cmd)
  );

  rett_state_dp #(
    .WIN_COUNT(WIN_COUNT), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .execStb(execStb), .cmd(cmd),
    .supMode(supMode), .prevSup(prevSup), .trapEn(trapEn),
    .winPtr(winPtr), .retAddr(retAddr),
    .branchReq(branchReq), .branchTarget(branchTarget),
    .trapReq(trapReq), .trapType(trapType),
    .outSup(outSup), .outPrevSup(outPrevSup),
    .outTrapEn(outTrapEn), .outWinPtr(outWinPtr)
  );

endmodule

// File: tb/rett_unit_bench.sv
`timescale 1ns/1ps
module rett_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execStb = 1'b0;
  logic        supMode = 1'b0, prevSup = 1'b0, trapEn = 1'b0;
  logic [2:0]  winPtr = '0;
  logic [7:0]  winInvalid = '0;
  logic [31:0] retAddr = '0;
  logic        branchReq, trapReq, outSup, outPrevSup, outTrapEn;
  logic [31:0] branchTarget;
  logic [7:0]  trapType;
  logic [2:0]  outWinPtr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct {
    logic        isTrap;
    logic [7:0]  tt;
    logic [31:0] tgt;
    logic        sup, psup, en;
    logic [2:0]  wp;
    string       tag;
  } expT;

  expT scoreQ[$];
  expT lastExp;

  always #5 clk = ~clk;

  rett_unit u_rett_unit (
    .clk(clk), .rstN(rstN), .execStb(execStb), .supMode(supMode),
    .prevSup(prevSup), .trapEn(trapEn), .winPtr(winPtr),
    .winInvalid(winInvalid), .retAddr(retAddr),
    .branchReq(branchReq), .branchTarget(branchTarget),
    .trapReq(trapReq), .trapType(trapType), .outSup(outSup),
    .outPrevSup(outPrevSup), .outTrapEn(outTrapEn), .outWinPtr(outWinPtr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model from the requirements
  function automatic expT model(input logic s, input logic ps, input logic en,
                                input logic [2:0] wp, input logic [7:0] wim,
                                input logic [31:0] ra);
    expT e;
    logic [2:0] dest;
    dest = wp + 3'd1;
    e.tgt = ra;
    e.isTrap = 1'b1;
    e.psup = ps;
    e.sup = s; e.en = en; e.wp = wp;
    if (!s) begin e.tt = 8'h03; e.tag = "R2"; end
    else if (en) begin e.tt = 8'h02; e.tag = "R3"; end
    else if (wim[dest]) begin e.tt = 8'h06; e.tag = "R4"; end
    else if (ra[1:0] != 2'b00) begin e.tt = 8'h07; e.tag = "R5"; end
    else begin
      e.isTrap = 1'b0; e.tt = 8'h00; e.tag = "R6/R7";
      e.sup = ps; e.en = 1'b1; e.wp = dest;
    end
    return e;
  endfunction

  task automatic apply(input logic s, input logic ps, input logic en,
                       input logic [2:0] wp, input logic [7:0] wim, input logic [31:0] ra);
    @(negedge clk);
    supMode = s; prevSup = ps; trapEn = en; winPtr = wp; winInvalid = wim; retAddr = ra;
    execStb = 1'b1;
    scoreQ.push_back(model(s, ps, en, wp, wim, ra));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      execStb = 1'b0;
      {supMode, prevSup, trapEn} = 3'($urandom);
      winPtr = 3'($urandom);
      winInvalid = 8'($urandom);
      retAddr = $urandom;
    end
  endtask

  // Monitor: results are due on the edge that samples the strobe
  initial begin
    lastExp = '{isTrap: 1'b0, tt: 8'h00, tgt: 32'h0, sup: 1'b0, psup: 1'b0,
                en: 1'b0, wp: 3'd0, tag: ""};
    forever begin
      logic stbSeen;
      @(posedge clk);
      stbSeen = execStb;
      #2;
      if (rstN) begin
        if (stbSeen) begin
          expT e;
          if (scoreQ.size() == 0) begin
            chk("R9 unexpected strobe", 32'd1, 32'd0);
          end else begin
            e = scoreQ.pop_front();
            chk({e.tag, " trapReq R9"}, 32'(trapReq), 32'(e.isTrap));
            chk({e.tag, " branchReq R9"}, 32'(branchReq), 32'(!e.isTrap));
            if (e.isTrap) begin
              chk({e.tag, " trapType"}, 32'(trapType), 32'(e.tt));
              chk("R8 outSup", 32'(outSup), 32'(e.sup));
              chk("R8 outTrapEn", 32'(outTrapEn), 32'(e.en));
              chk("R8 outWinPtr", 32'(outWinPtr), 32'(e.wp));
              chk("R8 outPrevSup", 32'(outPrevSup), 32'(e.psup));
            end else begin
              chk("R7 branchTarget", branchTarget, e.tgt);
              chk("R6 outSup", 32'(outSup), 32'(e.sup));
              chk("R6 outTrapEn", 32'(outTrapEn), 32'(e.en));
              chk("R6 outWinPtr", 32'(outWinPtr), 32'(e.wp));
              chk("R6 outPrevSup", 32'(outPrevSup), 32'(e.psup));
            end
            lastExp = e;
          end
        end else begin
          chk("R9 idle branchReq", 32'(branchReq), 32'd0);
          chk("R9 idle trapReq", 32'(trapReq), 32'd0);
          chk("R10 hold outSup", 32'(outSup), 32'(lastExp.sup));
          chk("R10 hold outTrapEn", 32'(outTrapEn), 32'(lastExp.en));
          chk("R10 hold outWinPtr", 32'(outWinPtr), 32'(lastExp.wp));
          chk("R10 hold outPrevSup", 32'(outPrevSup), 32'(lastExp.psup));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 branchReq", 32'(branchReq), 32'd0);
    chk("R1 trapReq", 32'(trapReq), 32'd0);
    chk("R1 trapType", 32'(trapType), 32'd0);
    chk("R1 status", {28'd0, outSup, outPrevSup, outTrapEn, 1'b0}, 32'd0);
    chk("R1 outWinPtr", 32'(outWinPtr), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R2: privilege check wins over every other failure
    apply(1'b0, 1'b1, 1'b1, 3'd2, 8'hFF, 32'h0000_1003);
    apply(1'b0, 1'b0, 1'b0, 3'd5, 8'h00, 32'h4000_0000);
    // R3: trap-enable check wins over window and alignment
    apply(1'b1, 1'b0, 1'b1, 3'd0, 8'h02, 32'h0000_0002);
    // R4: destination window invalid, wrap 7 -> window 0
    apply(1'b1, 1'b1, 1'b0, 3'd7, 8'h01, 32'h0000_0001);
    apply(1'b1, 1'b0, 1'b0, 3'd3, 8'h10, 32'h0000_2000);
    idle(1);
    // R5: each misaligned low-bit pattern
    for (int k = 1; k < 4; k++) apply(1'b1, 1'b1, 1'b0, 3'd1, 8'h02 ^ 8'hFF ^ 8'hFF ^ 8'h02 ^ 8'hFB, 32'h8000_0000 | 32'(k));
    // R6/R7: success, including wrap 7 -> 0 with own window marked invalid
    apply(1'b1, 1'b0, 1'b0, 3'd7, 8'h80, 32'h4000_1230);
    apply(1'b1, 1'b1, 1'b0, 3'd3, 8'hEF, 32'hFFFF_FFFC);
    idle(3);
    // R8/R10: failure after success keeps incoming status
    apply(1'b1, 1'b1, 1'b1, 3'd6, 8'h00, 32'h0000_0010);
    idle(2);

    // Mixed patterns, including back-to-back strobes
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[0] | r[1], r[2], r[3] & r[4], r[7:5], 8'($urandom) & 8'($urandom),
            {$urandom} & (r[8] ? 32'hFFFF_FFFC : 32'hFFFF_FFFF));
      if (r[9]) idle(1 + int'(r[11:10]));
    end

    idle(4);
    if (scoreQ.size() != 0) chk("R9 pending results", 32'(scoreQ.size()), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule